// File: doc/BRIEF.md
# Filtered Pulse-Width Capture Receiver

This block watches one asynchronous digital input and measures how long the input stays at each level. Time is counted in ticks from a programmable prescaler. The input first passes through a two-flop synchroniser. An optional glitch filter then removes pulses that are too short to be real. Each run between two accepted edges is stored as one entry in a small local buffer. An entry holds the run's level and its length in ticks. The buffer is read through a plain address/data port.

A frame starts at the first accepted edge after capture is enabled. It ends when the input shows no accepted edge for longer than a programmable idle limit. At that point a zero-length marker entry is stored and a sticky done flag is raised. A write into a full buffer raises a sticky error flag, and capture halts until the write pointer is reset. Results land in the local buffer and not on an outgoing stream, so the block has no valid/ready edge. Every control and status pin is plain level or pulse signalling.

Top module: `pwcap_rx`

## Requirements
- R1: After the two-flop synchroniser, the filtered level takes a new input value only once that value has held for `filt_thr` consecutive clock cycles when `filt_en`=1, so shorter pulses produce no edge. With `filt_en`=0, or with `filt_thr` of 0 or 1, every synchronised change passes.
- R2: The prescaler issues one tick every `div_factor` clock cycles, and a factor of 0 or 1 gives a tick on every cycle. While `div_rst` is high the divider count is held at zero and no tick is issued.
- R3: Each accepted edge inside a frame stores one entry at the current write pointer and then increments `wr_ptr`. The entry has the level of the run that just ended in bit 15 (1 = high) and the run length in ticks in bits 14:0. The run length counts the ticks seen from the cycle of the previous edge up to, but not including, the cycle of this edge.
- R4: After enable, the first accepted edge starts the frame and stores no entry. While no edge has been seen, no timeout can occur.
- R5: A run length above 32767 ticks is stored as 32767.
- R6: The idle timeout fires when a tick arrives after the current run has already counted `idle_lim` ticks. It stores a marker entry with the current level in bit 15 and a length of 0, and it sets `done`.
- R7: `done` stays set until a `done_clr` pulse clears it. While it is set, no entries are stored.
- R8: With `rx_en` low, no entry is stored and `wr_ptr` does not change. Any frame in progress is abandoned.
- R9: A store attempted while `wr_ptr` equals the buffer depth (16) is dropped and sets `err`. `err` stays set, and capture halts while it is set.
- R10: A `wptr_rst` pulse returns `wr_ptr` to 0 and clears `err`. Any store in that same cycle is dropped.
- R11: After reset, `done`, `err` and `wr_ptr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous input being measured |
| rx_en | input | 1 | Capture enable |
| div_factor | input | 8 | Clock cycles per tick (0 and 1 both mean 1) |
| div_rst | input | 1 | Clears the prescaler count and suppresses ticks |
| filt_en | input | 1 | Enables the glitch filter |
| filt_thr | input | 8 | Minimum accepted pulse width, in clock cycles |
| idle_lim | input | 16 | Idle limit, in ticks |
| done_clr | input | 1 | Write-one pulse that clears `done` |
| wptr_rst | input | 1 | Resets the write pointer and clears `err` |
| rd_addr | input | 4 | Buffer read address |
| rd_data | output | 16 | Entry at `rd_addr`: level in bit 15, length in bits 14:0 |
| wr_ptr | output | 5 | Number of entries stored |
| done | output | 1 | Sticky frame-complete flag |
| err | output | 1 | Sticky buffer-overflow flag |

## Verification
The input path has a fixed delay. A change on `sig_in` reaches the filtered level after two synchroniser cycles plus max(`filt_thr`,1) cycles when filtering is on, or one cycle when it is off. The edge is detected one cycle after that. `wr_ptr`, `done` and `err` are registered, so they change on the clock edge that ends the edge-detect or timeout cycle.

The bench keeps a behavioural model that is advanced on the same rising edge as the design. It compares the flags and pointer on every falling edge, so no fixed delay has to be guessed. The hand-computed entry values are read back through `rd_data` after each frame has settled. `rd_data` is combinational and is sampled one time step after the address is set.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
  localparam int LEN_W   = 15;
  localparam int ENTRY_W = LEN_W + 1;

  typedef struct packed {
    logic             level;
    logic [LEN_W-1:0] len;
  } run_entry_t;
endpackage

// File: rtl/pwcap_sync_filter.sv
module pwcap_sync_filter #(
  parameter int STAGES = 2,
  parameter int THR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             filt_en,
  input  logic [THR_W-1:0] filt_thr,
  output logic             level_o
);
  logic [STAGES-1:0] sync_q;
  logic [THR_W-1:0]  cnt_q;
  logic [THR_W-1:0]  thr_eff;
  logic              s_in;
  logic              level_q;

  assign s_in    = sync_q[STAGES-1];
  assign thr_eff = filt_en ? filt_thr : '0;
  assign level_o = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], sig_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (s_in != level_q) begin
      if (({1'b0, cnt_q} + 1'b1) >= {1'b0, thr_eff}) begin
        level_q <= s_in;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  // R1: the filtered level only moves to the value the synchroniser held
  a_r1_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> (level_q == $past(s_in)));
endmodule

// File: rtl/pwcap_prescaler.sv
module pwcap_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_factor,
  input  logic             div_rst,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = !div_rst && (({1'b0, cnt_q} + 1'b1) >= {1'b0, div_factor});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (div_rst || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  a_r2_div_clear: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |=> (cnt_q == '0));
endmodule

// File: rtl/pwcap_tracker.sv
module pwcap_tracker
  import pwcap_pkg::*;
#(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level_i,
  input  logic              tick_i,
  input  logic              rx_en,
  input  logic [IDLE_W-1:0] idle_lim,
  input  logic              done_clr,
  input  logic              wptr_rst,
  input  logic              buf_full,
  output logic              wr_req_o,
  output run_entry_t        wr_data_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [IDLE_W-1:0] MAX_LEN = IDLE_W'((1 << LEN_W) - 1);
  localparam logic [IDLE_W-1:0] CNT_TOP = '1;

  logic              lvl_q, run_q, done_q, err_q;
  logic [IDLE_W-1:0] since_q;
  logic              active, ev, timeout;
  logic [LEN_W-1:0]  len_sat;

  assign active  = rx_en && !done_q && !err_q;
  assign ev      = level_i != lvl_q;
  assign len_sat = (since_q > MAX_LEN) ? MAX_LEN[LEN_W-1:0] : since_q[LEN_W-1:0];

  always_comb begin
    wr_req_o  = 1'b0;
    wr_data_o = '0;
    timeout   = 1'b0;
    if (active && run_q) begin
      if (ev) begin
        wr_req_o        = 1'b1;
        wr_data_o.level = lvl_q;
        wr_data_o.len   = len_sat;
      end else if (tick_i && (since_q >= idle_lim)) begin
        wr_req_o        = 1'b1;
        wr_data_o.level = lvl_q;
        timeout         = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      run_q   <= 1'b0;
      since_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      lvl_q <= level_i;
      if (!active)            run_q <= 1'b0;
      else if (!run_q && ev)  run_q <= 1'b1;
      if (active && ev)
        since_q <= tick_i ? IDLE_W'(1) : '0;
      else if (active && run_q && tick_i && !timeout && since_q != CNT_TOP)
        since_q <= since_q + 1'b1;
      if (timeout)       done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (wptr_rst)                 err_q <= 1'b0;
      else if (wr_req_o && buf_full) err_q <= 1'b1;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !done_clr) |=> done_q);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !wptr_rst) |=> err_q);
  a_r6_done_on_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !done_clr && $past(!done_q)) |=> !done_q || $past(wr_req_o));
endmodule

// File: rtl/pwcap_buffer.sv
module pwcap_buffer #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_data,
  input  logic          wptr_rst,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [AW:0]   wr_ptr,
  output logic          full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  ptr_q;
  logic         do_wr;

  assign full    = ptr_q == (AW+1)'(DEPTH);
  assign do_wr   = wr_req && !full && !wptr_rst;
  assign wr_ptr  = ptr_q;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[ptr_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (wptr_rst) ptr_q <= '0;
    else if (do_wr)    ptr_q <= ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_n) a_r9_ptr_bound: assert (ptr_q <= (AW+1)'(DEPTH));
  end
  a_r10_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_rst |=> (ptr_q == '0));
endmodule

// File: rtl/pwcap_rx.sv
module pwcap_rx
  import pwcap_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 8,
  parameter int THR_W  = 8,
  parameter int IDLE_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sig_in,
  input  logic               rx_en,
  input  logic [DIV_W-1:0]   div_factor,
  input  logic               div_rst,
  input  logic               filt_en,
  input  logic [THR_W-1:0]   filt_thr,
  input  logic [IDLE_W-1:0]  idle_lim,
  input  logic               done_clr,
  input  logic               wptr_rst,
  input  logic [AW-1:0]      rd_addr,
  output logic [ENTRY_W-1:0] rd_data,
  output logic [AW:0]        wr_ptr,
  output logic               done,
  output logic               err
);
  logic       level, tick, wr_req, full;
  run_entry_t wr_data;

  pwcap_sync_filter #(.STAGES(2), .THR_W(THR_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .filt_en(filt_en),
    .filt_thr(filt_thr), .level_o(level));

  pwcap_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_factor(div_factor), .div_rst(div_rst),
    .tick_o(tick));

  pwcap_tracker #(.IDLE_W(IDLE_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .level_i(level), .tick_i(tick), .rx_en(rx_en),
    .idle_lim(idle_lim), .done_clr(done_clr), .wptr_rst(wptr_rst),
    .buf_full(full), .wr_req_o(wr_req), .wr_data_o(wr_data),
    .done_o(done), .err_o(err));

  pwcap_buffer #(.DEPTH(DEPTH), .W(ENTRY_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
    .wptr_rst(wptr_rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_ptr(wr_ptr), .full(full));

  a_r8_off_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !wptr_rst) |=> $stable(wr_ptr));
endmodule

// File: tb/test_pwcap_rx.sv
module test_pwcap_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig_in = 1'b0, rx_en = 1'b0, div_rst = 1'b0, filt_en = 1'b0;
  logic        done_clr = 1'b0, wptr_rst = 1'b0;
  logic [7:0]  div_factor = 8'd1, filt_thr = 8'd0;
  logic [15:0] idle_lim = 16'd20;
  logic [3:0]  rd_addr = 4'd0;
  logic [15:0] rd_data;
  logic [4:0]  wr_ptr;
  logic        done, err;
  int total = 0, bad = 0;

  pwcap_rx i_pwcap_rx (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .rx_en(rx_en),
    .div_factor(div_factor), .div_rst(div_rst), .filt_en(filt_en),
    .filt_thr(filt_thr), .idle_lim(idle_lim), .done_clr(done_clr),
    .wptr_rst(wptr_rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_ptr(wr_ptr), .done(done), .err(err));

  always #10 clk = ~clk;

  // behavioural reference model
  int m_s1, m_s2, m_f, m_fc, m_div, m_lvl, m_run, m_since, m_done, m_err, m_wp;
  int m_mem [16];

  always @(posedge clk or negedge rst_n) begin : model
    int thr, n_f, n_fc, n_div, n_since, n_run, n_done, n_err, n_wp, dat;
    bit tick, ev, act, wr, tmo;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_f = 0; m_fc = 0; m_div = 0; m_lvl = 0;
      m_run = 0; m_since = 0; m_done = 0; m_err = 0; m_wp = 0;
    end else begin
      tick  = !div_rst && (m_div + 1 >= int'(div_factor));
      n_div = (div_rst || tick) ? 0 : m_div + 1;
      thr   = filt_en ? int'(filt_thr) : 0;
      n_f = m_f; n_fc = 0;
      if (m_s2 != m_f) begin
        if (m_fc + 1 >= thr) n_f = m_s2;
        else n_fc = m_fc + 1;
      end
      ev  = m_f != m_lvl;
      act = rx_en && m_done == 0 && m_err == 0;
      wr = 0; tmo = 0; dat = 0; n_since = m_since; n_run = m_run;
      if (act && m_run == 1) begin
        if (ev) begin
          wr = 1; dat = m_lvl * 32768 + (m_since > 32767 ? 32767 : m_since);
        end else if (tick && m_since >= int'(idle_lim)) begin
          wr = 1; dat = m_lvl * 32768; tmo = 1;
        end
      end
      if (act && ev) n_since = tick ? 1 : 0;
      else if (act && m_run == 1 && tick && !tmo && m_since < 65535) n_since = m_since + 1;
      if (!act) n_run = 0;
      else if (m_run == 0 && ev) n_run = 1;
      n_wp = m_wp; n_err = m_err;
      if (wptr_rst) begin n_wp = 0; n_err = 0; end
      else if (wr) begin
        if (m_wp < 16) begin m_mem[m_wp] = dat; n_wp = m_wp + 1; end
        else n_err = 1;
      end
      n_done = tmo ? 1 : (done_clr ? 0 : m_done);
      m_lvl = m_f; m_f = n_f; m_fc = n_fc; m_s2 = m_s1; m_s1 = int'(sig_in);
      m_div = n_div; m_since = n_since; m_run = n_run;
      m_wp = n_wp; m_err = n_err; m_done = n_done;
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      total += 3;
      if (int'(wr_ptr) != m_wp) begin bad++; $display("FAIL R3 wr_ptr act=%0d exp=%0d", wr_ptr, m_wp); end
      if (int'(done) != m_done) begin bad++; $display("FAIL R6/R7 done act=%0d exp=%0d", done, m_done); end
      if (int'(err) != m_err) begin bad++; $display("FAIL R9 err act=%0d exp=%0d", err, m_err); end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic entry(input string tag, input int idx, input int exp);
    rd_addr = 4'(idx);
    #1;
    chk(tag, int'(rd_data), exp);
    chk({tag, " model"}, int'(rd_data), m_mem[idx]);
  endtask

  task automatic pulse_clr();
    done_clr = 1; wptr_rst = 1; cyc(1); done_clr = 0; wptr_rst = 0; cyc(1);
  endtask

  task automatic level_for(input logic v, input int n);
    sig_in = v; cyc(n);
  endtask

  initial begin : watchdog
    cyc(200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    chk("R11 done", done, 0); chk("R11 err", err, 0); chk("R11 wr_ptr", wr_ptr, 0);

    // R3 R6: basic frame, tick every cycle
    rx_en = 1; idle_lim = 20; div_factor = 1;
    level_for(0, 5); level_for(1, 5); level_for(0, 7); level_for(1, 9); level_for(0, 40);
    chk("R6 done", done, 1); chk("R3 wr_ptr", wr_ptr, 4);
    entry("R3 e0", 0, 16'h8005); entry("R3 e1", 1, 16'h0007);
    entry("R3 e2", 2, 16'h8009); entry("R6 marker", 3, 16'h0000);

    // R7: sticky done, no stores while set
    level_for(1, 6); level_for(0, 6); level_for(1, 6); level_for(0, 20);
    chk("R7 done held", done, 1); chk("R7 no store", wr_ptr, 4);
    done_clr = 1; cyc(1); done_clr = 0; cyc(1);
    chk("R7 cleared", done, 0);
    wptr_rst = 1; cyc(1); wptr_rst = 0; cyc(1);
    chk("R10 ptr zero", wr_ptr, 0);

    // R1: glitch filter, threshold 4
    rx_en = 0; cyc(2); rx_en = 1; filt_en = 1; filt_thr = 4; idle_lim = 50;
    level_for(1, 10); level_for(0, 2); level_for(1, 10); level_for(0, 6);
    level_for(1, 10); level_for(0, 80);
    chk("R1 count", wr_ptr, 4);
    entry("R1 merged", 0, 16'h8016); entry("R1 short low", 1, 16'h0006);
    entry("R1 high", 2, 16'h800A);
    filt_en = 0; filt_thr = 0;

    // R2: divide by four
    pulse_clr(); rx_en = 0; cyc(2); rx_en = 1; div_factor = 4; idle_lim = 12;
    level_for(1, 40); level_for(0, 40); level_for(1, 80);
    chk("R2 done", done, 1);
    entry("R2 e0", 0, 16'h800A); entry("R2 e1", 1, 16'h000A);
    entry("R6 high marker", 2, 16'h8000);

    // R2: divider reset stops ticks, so no timeout
    pulse_clr(); rx_en = 0; cyc(2); rx_en = 1; div_factor = 1; idle_lim = 5;
    div_rst = 1;
    level_for(0, 5); level_for(1, 5); level_for(0, 100);
    chk("R2 div_rst no timeout", done, 0);
    div_rst = 0; cyc(20);
    chk("R2 ticks resume", done, 1);

    // R8: disabled capture ignores input
    pulse_clr(); rx_en = 0; idle_lim = 3;
    for (int i = 0; i < 10; i++) begin level_for(1, 4); level_for(0, 4); end
    chk("R8 wr_ptr", wr_ptr, 0); chk("R8 done", done, 0);

    // R4: no edge after enable, no timeout
    rx_en = 1; level_for(0, 200);
    chk("R4 no timeout", done, 0); chk("R4 no entry", wr_ptr, 0);

    // R9: overflow
    idle_lim = 100;
    for (int i = 0; i < 20; i++) begin level_for(1, 2); level_for(0, 2); end
    cyc(150);
    chk("R9 err", err, 1); chk("R9 full ptr", wr_ptr, 16); chk("R9 halted", done, 0);
    wptr_rst = 1; cyc(1); wptr_rst = 0; cyc(1);
    chk("R10 err clear", err, 0); chk("R10 ptr", wr_ptr, 0);

    // R5: saturation of long run
    rx_en = 0; cyc(2); rx_en = 1; idle_lim = 16'hFFFF;
    level_for(1, 33000); level_for(0, 10);
    chk("R5 count", wr_ptr, 1);
    entry("R5 sat", 0, 16'hFFFF);
    rx_en = 0; cyc(5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule